// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt line to a host processor. Each line can be captured on its rising edge or followed as a level. Pending requests that are not masked compete by priority, and the line to the host rises only when the best pending request outranks everything already being serviced. Priority is either fixed, with input 0 highest, or rotating, where the level whose service has just ended drops to the bottom.

The host answers the interrupt with two acknowledge pulses. The first moves the winning request from the pending set into the in-service set. The second makes the block present an 8-bit vector for one cycle. The vector is a programmable 5-bit base in bits 7:3 joined to the 3-bit level number in bits 2:0. Service ends in one of three ways: a specific end-of-interrupt command that names a level, a non-specific command that clears the highest-priority in-service level, or an automatic clear at the second acknowledge.

The host programs the block and reads its state through a small register port. Writes take effect at the clock edge. Reads are combinational on the address. The vector output is qualified by `vec_valid` alone and has no back-pressure, because the host asked for it with the acknowledge.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are 0, and every register reads 0: mask, mode, trigger, base, pending and in-service. Register map, by 3-bit address: 0 is the mask; 1 is the mode (bit 0 rotate, bit 1 auto end-of-interrupt); 2 is the trigger select (bit i = 1 makes input i level-triggered); 3 is the vector base in bits 7:3; writing 4 issues an end-of-interrupt, reading 4 returns the pending set; reading 5 returns the in-service set.
- R2: On an edge-triggered input, a rising edge sets its pending bit. The bit stays set after the line falls, until that request is acknowledged.
- R3: On a level-triggered input, the pending bit follows the line. A request that drops before it is acknowledged disappears and `int_req` falls.
- R4: A mask bit of 1 keeps that input from raising `int_req`, but its pending bit is still recorded. Clearing the mask bit lets it through.
- R5: With fixed priority, the lowest-numbered unmasked pending input wins the acknowledge.
- R6: `int_req` is 1 only while an unmasked pending request has strictly higher priority than every in-service bit. A higher-priority request arriving during a service raises it again (nesting).
- R7: The first acknowledge while `int_req` is 1 sets the winner's in-service bit, clears its pending bit and holds `int_req` at 0. The second acknowledge makes `vec_valid` 1 for exactly the next cycle, with `vec_data` equal to {base, level}.
- R8: Writing address 4 with bit 3 = 1 clears the in-service bit named by bits 2:0.
- R9: Writing address 4 with bit 3 = 0 clears the highest-priority in-service bit.
- R10: With mode bit 1 set, the in-service bit is cleared at the second acknowledge, with no end-of-interrupt write needed.
- R11: With mode bit 0 set, the level whose in-service bit is cleared becomes the lowest priority, and the level after it in circular order becomes the highest.
- R12: An acknowledge while `int_req` is 0 and no sequence is open has no effect. The next real acknowledge is again a first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| int_req | output | 1 | Interrupt request to host |
| ack | input | 1 | Acknowledge pulse from host, one cycle per step |
| vec_valid | output | 1 | Vector present this cycle |
| vec_data | output | 8 | Vector number {base, level} |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |

## Verification
The arbitration is exercised with the following patterns, each of which tells a different fault apart:
- A lone edge pulse shows whether capture is latched or transparent.
- A masked line followed by an unmask separates recording from presentation.
- Two simultaneous edges show which level wins under fixed priority.
- A later lower-numbered pulse during a service checks nesting.
- Non-specific commands with two levels in service show which bit is chosen.
- Under rotation, the same two-line pattern must pick the opposite winner from the fixed case, which exposes a stale or misapplied priority pointer.
- A level line that drops before acknowledge, and an acknowledge with nothing pending, check that spurious stimulus leaves no state behind.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd2;
  localparam logic [ADDR_W-1:0] A_BASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_EOI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ISR  = 3'd5;

  typedef enum logic {SEQ_IDLE, SEQ_HELD} seq_state_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] trig_lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (trig_lvl[i]) irr_d[i] = irq[i] & ~clr[i];
      else             irr_d[i] = (irr[i] & ~clr[i]) | (irq[i] & ~prev_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq;
      irr    <= irr_d;
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] low,
  output logic          any,
  output logic [LW-1:0] lvl
);
  always_comb begin
    any = 1'b0;
    lvl = '0;
    for (int k = N; k >= 1; k--) begin
      logic [LW-1:0] idx;
      idx = LW'((int'(low) + k) % N);
      if (req[idx]) begin
        any = 1'b1;
        lvl = idx;
      end
    end
  end
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import irq_hub_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          can_grant,
  input  logic [LW-1:0] win_lvl,
  output logic          grant,
  output logic          fin,
  output logic          busy,
  output logic [LW-1:0] lvl_q
);
  seq_state_e st_q;

  assign busy  = (st_q == SEQ_HELD);
  assign grant = ack && !busy && can_grant;
  assign fin   = ack && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      lvl_q <= '0;
    end else if (grant) begin
      st_q  <= SEQ_HELD;
      lvl_q <= win_lvl;
    end else if (fin) begin
      st_q  <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  output logic              int_req,
  input  logic              ack,
  output logic              vec_valid,
  output logic [DW-1:0]     vec_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata
);
  localparam int LW     = $clog2(N);
  localparam int BASE_W = DW - LW;

  logic [N-1:0]      mask_q, trig_q, irr_q, isr_q, isr_d;
  logic [N-1:0]      ack_clr, eoi_clr;
  logic [1:0]        mode_q;
  logic [BASE_W-1:0] base_q;
  logic [LW-1:0]     low_q, eff_low;
  logic              pend_any, srv_any, busy, grant, fin;
  logic [LW-1:0]     pend_lvl, srv_lvl, ack_lvl;
  logic              eoi_wr, clr_any;
  logic [LW-1:0]     clr_lvl;

  function automatic logic [LW-1:0] rank(input logic [LW-1:0] l, input logic [LW-1:0] lo);
    return LW'(l - lo - LW'(1));
  endfunction

  assign eff_low = mode_q[0] ? low_q : LW'(N - 1);

  irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq(irq_in), .trig_lvl(trig_q),
    .clr(ack_clr), .irr(irr_q)
  );

  prio_pick #(.N(N), .LW(LW)) u_pend (
    .req(irr_q & ~mask_q), .low(eff_low), .any(pend_any), .lvl(pend_lvl)
  );

  prio_pick #(.N(N), .LW(LW)) u_srv (
    .req(isr_q), .low(eff_low), .any(srv_any), .lvl(srv_lvl)
  );

  assign int_req = !busy && pend_any &&
                   (!srv_any || (rank(pend_lvl, eff_low) < rank(srv_lvl, eff_low)));

  ack_seq #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack(ack), .can_grant(int_req),
    .win_lvl(pend_lvl), .grant(grant), .fin(fin), .busy(busy), .lvl_q(ack_lvl)
  );

  assign ack_clr = grant ? (N'(1) << pend_lvl) : '0;
  assign eoi_wr  = cfg_we && (cfg_addr == A_EOI);

  always_comb begin
    clr_any = 1'b0;
    clr_lvl = '0;
    if (fin && mode_q[1]) begin
      clr_any = 1'b1;
      clr_lvl = ack_lvl;
    end else if (eoi_wr && cfg_wdata[3]) begin
      clr_any = 1'b1;
      clr_lvl = cfg_wdata[LW-1:0];
    end else if (eoi_wr && srv_any) begin
      clr_any = 1'b1;
      clr_lvl = srv_lvl;
    end
  end

  assign eoi_clr = clr_any ? (N'(1) << clr_lvl) : '0;
  assign isr_d   = (isr_q & ~eoi_clr) | ack_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      trig_q    <= '0;
      mode_q    <= '0;
      base_q    <= '0;
      isr_q     <= '0;
      low_q     <= LW'(N - 1);
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      isr_q     <= isr_d;
      vec_valid <= fin;
      if (fin) vec_data <= {base_q, ack_lvl};
      if (clr_any && mode_q[0]) low_q <= clr_lvl;
      if (cfg_we) begin
        case (cfg_addr)
          A_MASK:  mask_q <= cfg_wdata[N-1:0];
          A_MODE:  mode_q <= cfg_wdata[1:0];
          A_TRIG:  trig_q <= cfg_wdata[N-1:0];
          A_BASE:  base_q <= cfg_wdata[DW-1:LW];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      A_MASK:  cfg_rdata = DW'(mask_q);
      A_MODE:  cfg_rdata = DW'(mode_q);
      A_TRIG:  cfg_rdata = DW'(trig_q);
      A_BASE:  cfg_rdata = {base_q, LW'(0)};
      A_EOI:   cfg_rdata = DW'(irr_q);
      A_ISR:   cfg_rdata = DW'(isr_q);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          int_req,
  input logic          busy,
  input logic          vec_valid,
  input logic          cfg_we,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  isr_q,
  input logic [1:0]    mode_q,
  input logic [LW-1:0] ack_lvl
);
  p_quiet_while_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !int_req);

  p_grant_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req) |=> (isr_q != '0));

  p_vec_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_vec_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr_q & ~mask_q) != '0));

  p_auto_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && busy && mode_q[1]) |=> !isr_q[$past(ack_lvl)]);

  p_idle_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !busy && !int_req && !cfg_we) |=> (isr_q == $past(isr_q)));
endmodule

bind prio_irq_hub irq_hub_chk #(.N(N), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .int_req(int_req), .busy(busy),
  .vec_valid(vec_valid), .cfg_we(cfg_we), .irr_q(irr_q), .mask_q(mask_q),
  .isr_q(isr_q), .mode_q(mode_q), .ack_lvl(ack_lvl)
);

// File: tb/test_prio_irq_hub.sv
`timescale 1ns/1ps
module test_prio_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       int_req, ack = 1'b0, vec_valid;
  logic [7:0] vec_data;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_hub i_prio_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_req(int_req), .ack(ack),
    .vec_valid(vec_valid), .vec_data(vec_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_irq(input logic [7:0] m);
    irq_in = irq_in | m; tick(); irq_in = irq_in & ~m;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 int_req", {7'b0, int_req}, 8'h00);
    chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register", d, 8'h00);
    end
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(3'd3, 8'hA8);
    pulse_irq(8'h08);
    tick();
    chk("R2 int_req held", {7'b0, int_req}, 8'h01);
    rd(3'd4, d); chk("R2 pending", d, 8'h08);
    pulse_ack();
    chk("R7 int_req low", {7'b0, int_req}, 8'h00);
    rd(3'd5, d); chk("R7 in-service", d, 8'h08);
    rd(3'd4, d); chk("R7 pending cleared", d, 8'h00);
    chk("R7 no vector yet", {7'b0, vec_valid}, 8'h00);
    pulse_ack();
    chk("R7 vec_valid", {7'b0, vec_valid}, 8'h01);
    chk("R7 vec_data", vec_data, 8'hAB);
    tick();
    chk("R7 vec one cycle", {7'b0, vec_valid}, 8'h00);
    wr(3'd4, 8'h0B);
    rd(3'd5, d); chk("R8 specific eoi", d, 8'h00);
  endtask

  task automatic t_fixed();
    logic [7:0] d;
    pulse_irq(8'h24);
    pulse_ack();
    rd(3'd5, d); chk("R5 lower index wins", d, 8'h04);
    pulse_ack();
    chk("R5 vector level", vec_data, 8'hAA);
    chk("R6 lower prio held off", {7'b0, int_req}, 8'h00);
    pulse_irq(8'h01);
    chk("R6 nesting", {7'b0, int_req}, 8'h01);
    pulse_ack(); pulse_ack();
    rd(3'd5, d); chk("R6 nested isr", d, 8'h05);
    wr(3'd4, 8'h00);
    rd(3'd5, d); chk("R9 nonspecific top", d, 8'h04);
    chk("R6 still blocked", {7'b0, int_req}, 8'h00);
    wr(3'd4, 8'h00);
    rd(3'd5, d); chk("R9 second nonspecific", d, 8'h00);
    chk("R6 released", {7'b0, int_req}, 8'h01);
    pulse_ack(); pulse_ack();
    wr(3'd4, 8'h0D);
    rd(3'd5, d); chk("R8 clear level5", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(3'd0, 8'h10);
    pulse_irq(8'h10);
    chk("R4 masked quiet", {7'b0, int_req}, 8'h00);
    rd(3'd4, d); chk("R4 still recorded", d, 8'h10);
    wr(3'd0, 8'h00);
    chk("R4 unmasked", {7'b0, int_req}, 8'h01);
    pulse_ack(); pulse_ack();
    wr(3'd4, 8'h0C);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(3'd2, 8'h40);
    irq_in[6] = 1'b1; tick();
    chk("R3 level asserts", {7'b0, int_req}, 8'h01);
    irq_in[6] = 1'b0; tick();
    chk("R3 level drops", {7'b0, int_req}, 8'h00);
    rd(3'd4, d); chk("R3 pending gone", d, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_idle_ack();
    logic [7:0] d;
    pulse_ack();
    chk("R12 no vector", {7'b0, vec_valid}, 8'h00);
    rd(3'd5, d); chk("R12 isr untouched", d, 8'h00);
    pulse_irq(8'h80);
    pulse_ack();
    chk("R12 first step again", {7'b0, vec_valid}, 8'h00);
    rd(3'd5, d); chk("R12 isr set", d, 8'h80);
    pulse_ack();
    chk("R12 vector level7", vec_data, 8'hAF);
    wr(3'd4, 8'h0F);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    wr(3'd1, 8'h02);
    pulse_irq(8'h02);
    pulse_ack();
    rd(3'd5, d); chk("R10 isr during seq", d, 8'h02);
    pulse_ack();
    chk("R10 vector", vec_data, 8'hA9);
    rd(3'd5, d); chk("R10 auto cleared", d, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] d;
    wr(3'd1, 8'h01);
    pulse_irq(8'h04);
    pulse_ack(); pulse_ack();
    wr(3'd4, 8'h0A);
    pulse_irq(8'h12);
    pulse_ack();
    rd(3'd5, d); chk("R11 rotated winner", d, 8'h10);
    pulse_ack();
    wr(3'd4, 8'h00);
    rd(3'd5, d); chk("R11 nonspecific rotated", d, 8'h00);
    chk("R11 next pending", {7'b0, int_req}, 8'h01);
    pulse_ack();
    rd(3'd5, d); chk("R11 level1 served", d, 8'h02);
    pulse_ack();
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edge();
    t_fixed();
    t_mask();
    t_level();
    t_idle_ack();
    t_auto();
    t_rotate();
    tick();
    finish_run();
  end
endmodule